// File: doc/BRIEF.md
# Function Scope Detector

This block watches a processor's committed program counter and its register-file write traffic to decide when one chosen function invocation is live. A runtime monitor uses it to mark where a per-invocation trace opens and closes. It keeps a shadow copy of the stack pointer by snooping both register write ports. It opens the scope when a valid PC equals the function's start address, and it records the stack pointer seen at that moment as the frame address of the invocation.

The scope closes when the stack has grown by at least the frame size, the PC has left the prologue bytes, and the stack pointer then climbs back to or above the recorded frame address. The invocation is identified by its stack position, not by a return instruction. A recursive call of the same function therefore keeps the outer scope open, and the outer record is not replaced.

Top module: `func_scope_tracker`

## Requirements
- R1: After reset, `scope_active`, `entry_pulse` and `exit_pulse` are 0 and `frame_ptr` is 0. The shadow stack pointer starts at `SP_RESET`.
- R2: A write on either port whose 5-bit index equals 29 (`SP_INDEX`) loads the shadow stack pointer at that clock edge. Writes to any other index leave it unchanged. The shadow value is observed through `frame_ptr` at the next entry.
- R3: When both ports write index 29 in the same cycle, the port-2 data is kept.
- R4: With the scope idle, `pc_valid`=1 and `pc`=`FUNC_ADDR` at a clock edge set `scope_active` after that edge and raise `entry_pulse` for exactly one cycle. `frame_ptr` takes the shadow stack pointer held before that edge.
- R5: A PC equal to `FUNC_ADDR` while `pc_valid`=0 starts nothing.
- R6: Exit cannot happen while the prologue flag is set. The flag is set at entry and clears at the first edge with `pc_valid`=1 and `pc` outside [`FUNC_ADDR`, `FUNC_ADDR`+`PROLOGUE_BYTES`). Exit also cannot happen before the shadow SP has been at or below `frame_ptr`-`FRAME_BYTES`. Arming occurs at an edge where the flag is already clear and that depth holds.
- R7: Once armed, an edge at which the shadow SP is at or above `frame_ptr` clears `scope_active` and raises `exit_pulse` for exactly one cycle.
- R8: A PC match while the scope is active produces no `entry_pulse` and leaves `frame_ptr` unchanged. Stack movement that stays below the recorded frame never closes the scope.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_valid | input | 1 | `pc` holds a committed instruction address |
| pc | input | 32 | Program counter |
| wr1_en | input | 1 | Register write port 1 enable |
| wr1_idx | input | 5 | Register write port 1 index |
| wr1_data | input | 32 | Register write port 1 data |
| wr2_en | input | 1 | Register write port 2 enable |
| wr2_idx | input | 5 | Register write port 2 index |
| wr2_data | input | 32 | Register write port 2 data |
| scope_active | output | 1 | The tracked invocation is live |
| entry_pulse | output | 1 | One-cycle pulse on scope open |
| exit_pulse | output | 1 | One-cycle pulse on scope close |
| frame_ptr | output | 32 | Stack pointer recorded at entry |

## Verification
The bench uses the default parameters: start address 0x80000378, a 32-byte frame, a 12-byte prologue and a stack pointer that resets to zero. With a 12-byte window, PCs at 0x8000037C and 0x80000380 fall inside the prologue and 0x80000384 falls just past it. Directed calls place the stack at 0x1000 and 0x0FE0. These values reach the exact-depth arming boundary, the SP-equals-frame exit boundary and a nested call one frame deeper. A randomized phase then mixes stack pointer values around the frame with the window PCs.

// File: rtl/fsd_pkg.sv
package fsd_pkg;
  localparam int WORD_W = 32;
  localparam int IDX_W  = 5;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [IDX_W-1:0]  ridx_t;

  // Next shadow SP given both write ports; port 2 is applied last.
  function automatic word_t sp_pick(input logic e1, input ridx_t i1, input word_t d1,
                                    input logic e2, input ridx_t i2, input word_t d2,
                                    input word_t cur, input ridx_t sp_idx);
    word_t r;
    r = cur;
    if (e1 && i1 == sp_idx) r = d1;
    if (e2 && i2 == sp_idx) r = d2;
    return r;
  endfunction

  // Address lies in [base, base+len).
  function automatic logic in_window(input word_t a, input word_t base, input word_t len);
    return (a >= base) && ((a - base) < len);
  endfunction

  // Stack has grown by at least size below the frame (no wrap).
  function automatic logic frame_pushed(input word_t sp, input word_t frame, input word_t size);
    logic [WORD_W:0] lhs;
    lhs = {1'b0, sp} + {1'b0, size};
    return lhs <= {1'b0, frame};
  endfunction

  // Stack has been released back to the frame or above.
  function automatic logic frame_popped(input word_t sp, input word_t frame);
    return sp >= frame;
  endfunction
endpackage

// File: rtl/fsd_sp_shadow.sv
module fsd_sp_shadow
  import fsd_pkg::*;
#(
  parameter int    SP_INDEX = 29,
  parameter word_t SP_RESET = '0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr1_en,
  input  ridx_t wr1_idx,
  input  word_t wr1_data,
  input  logic  wr2_en,
  input  ridx_t wr2_idx,
  input  word_t wr2_data,
  output word_t sp_q
);
  localparam ridx_t SP_IDX = ridx_t'(SP_INDEX);

  logic hit1, hit2;
  assign hit1 = wr1_en && (wr1_idx == SP_IDX);
  assign hit2 = wr2_en && (wr2_idx == SP_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) sp_q <= SP_RESET;
    else        sp_q <= sp_pick(wr1_en, wr1_idx, wr1_data, wr2_en, wr2_idx, wr2_data, sp_q, SP_IDX);
  end

  assert_port2_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit1 && hit2 |=> sp_q == $past(wr2_data));

  assert_other_index_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !hit1 && !hit2 |=> $stable(sp_q));
endmodule

// File: rtl/fsd_entry_match.sv
module fsd_entry_match
  import fsd_pkg::*;
#(
  parameter word_t FUNC_ADDR      = 32'h8000_0378,
  parameter int    PROLOGUE_BYTES = 12
) (
  input  logic  pc_valid,
  input  word_t pc,
  output logic  start_hit,
  output logic  left_prologue
);
  localparam word_t PRO_LEN = word_t'(PROLOGUE_BYTES);

  assign start_hit     = pc_valid && (pc == FUNC_ADDR);
  assign left_prologue = pc_valid && !in_window(pc, FUNC_ADDR, PRO_LEN);

  always_comb begin
    if (start_hit) assert_hit_not_leaving_R6: assert (!left_prologue || PROLOGUE_BYTES == 0);
  end
endmodule

// File: rtl/fsd_frame_track.sv
module fsd_frame_track
  import fsd_pkg::*;
#(
  parameter int FRAME_BYTES = 32
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pc_valid,
  input  logic  start_hit,
  input  logic  left_prologue,
  input  word_t sp,
  output logic  scope_q,
  output logic  entry_q,
  output logic  exit_q,
  output word_t frame_q
);
  localparam word_t FRAME_SZ = word_t'(FRAME_BYTES);

  logic prologue_q, armed_q;
  logic open_ev, arm_ev, close_ev;

  assign open_ev  = !scope_q && start_hit;
  assign arm_ev   = scope_q && !armed_q && !prologue_q && frame_pushed(sp, frame_q, FRAME_SZ);
  assign close_ev = scope_q && armed_q && frame_popped(sp, frame_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scope_q    <= 1'b0;
      entry_q    <= 1'b0;
      exit_q     <= 1'b0;
      frame_q    <= '0;
      prologue_q <= 1'b0;
      armed_q    <= 1'b0;
    end else begin
      entry_q <= open_ev;
      exit_q  <= close_ev;
      if (open_ev) begin
        scope_q    <= 1'b1;
        frame_q    <= sp;
        prologue_q <= 1'b1;
        armed_q    <= 1'b0;
      end else if (close_ev) begin
        scope_q    <= 1'b0;
        armed_q    <= 1'b0;
        prologue_q <= 1'b0;
      end else begin
        if (arm_ev) armed_q <= 1'b1;
        if (scope_q && left_prologue) prologue_q <= 1'b0;
      end
    end
  end

  assert_entry_opens_R4: assert property (@(posedge clk) disable iff (!rst_n)
    entry_q |-> scope_q && !$past(scope_q));

  assert_exit_needs_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exit_q |-> !scope_q && $past(armed_q));

  assert_no_arm_in_prologue_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> !$past(prologue_q));

  assert_frame_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    scope_q && $past(scope_q) |-> $stable(frame_q));

  assert_invalid_pc_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_valid && !scope_q |=> !entry_q);

  assert_pulses_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(entry_q && exit_q));
endmodule

// File: rtl/func_scope_tracker.sv
module func_scope_tracker
  import fsd_pkg::*;
#(
  parameter logic [31:0] FUNC_ADDR      = 32'h8000_0378,
  parameter int          FRAME_BYTES    = 32,
  parameter int          PROLOGUE_BYTES = 12,
  parameter int          SP_INDEX       = 29,
  parameter logic [31:0] SP_RESET       = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pc_valid,
  input  logic [31:0] pc,
  input  logic        wr1_en,
  input  logic [4:0]  wr1_idx,
  input  logic [31:0] wr1_data,
  input  logic        wr2_en,
  input  logic [4:0]  wr2_idx,
  input  logic [31:0] wr2_data,
  output logic        scope_active,
  output logic        entry_pulse,
  output logic        exit_pulse,
  output logic [31:0] frame_ptr
);
  word_t sp_shadow;
  logic  start_hit, left_prologue;

  fsd_sp_shadow #(.SP_INDEX(SP_INDEX), .SP_RESET(SP_RESET)) u_sp (
    .clk(clk), .rst_n(rst_n),
    .wr1_en(wr1_en), .wr1_idx(wr1_idx), .wr1_data(wr1_data),
    .wr2_en(wr2_en), .wr2_idx(wr2_idx), .wr2_data(wr2_data),
    .sp_q(sp_shadow)
  );

  fsd_entry_match #(.FUNC_ADDR(FUNC_ADDR), .PROLOGUE_BYTES(PROLOGUE_BYTES)) u_match (
    .pc_valid(pc_valid), .pc(pc),
    .start_hit(start_hit), .left_prologue(left_prologue)
  );

  fsd_frame_track #(.FRAME_BYTES(FRAME_BYTES)) u_track (
    .clk(clk), .rst_n(rst_n), .pc_valid(pc_valid),
    .start_hit(start_hit), .left_prologue(left_prologue), .sp(sp_shadow),
    .scope_q(scope_active), .entry_q(entry_pulse), .exit_q(exit_pulse), .frame_q(frame_ptr)
  );
endmodule

// File: tb/func_scope_tracker_tb.sv
module func_scope_tracker_tb;
  localparam logic [31:0] FA = 32'h8000_0378;

  logic        clk = 0, rst_n = 0;
  logic        pc_valid = 0;
  logic [31:0] pc = 0;
  logic        wr1_en = 0, wr2_en = 0;
  logic [4:0]  wr1_idx = 0, wr2_idx = 0;
  logic [31:0] wr1_data = 0, wr2_data = 0;
  logic        scope_active, entry_pulse, exit_pulse;
  logic [31:0] frame_ptr;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  longint m_sp = 0, m_frame = 0;
  bit m_scope = 0, m_entry = 0, m_exit = 0, m_pro = 0, m_armed = 0;

  always #4 clk = ~clk;

  func_scope_tracker u_dut (.*);

  always @(posedge clk) begin
    longint nsp;
    bit hit, outside, pushed, popped;
    if (!rst_n) begin
      m_sp = 0; m_frame = 0; m_scope = 0; m_entry = 0; m_exit = 0; m_pro = 0; m_armed = 0;
    end else begin
      nsp = m_sp;
      if (wr1_en && wr1_idx == 29) nsp = wr1_data;
      if (wr2_en && wr2_idx == 29) nsp = wr2_data;
      hit = pc_valid && pc == FA;
      outside = pc_valid && !(pc >= FA && pc < FA + 12);
      pushed = (m_sp + 32) <= m_frame;
      popped = m_sp >= m_frame;
      m_entry = 0; m_exit = 0;
      if (!m_scope && hit) begin
        m_scope = 1; m_entry = 1; m_frame = m_sp; m_pro = 1; m_armed = 0;
      end else if (m_scope && m_armed && popped) begin
        m_scope = 0; m_exit = 1; m_armed = 0; m_pro = 0;
      end else if (m_scope) begin
        if (!m_armed && !m_pro && pushed) m_armed = 1;
        if (outside) m_pro = 0;
      end
      m_sp = nsp;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R4 scope_active", scope_active, m_scope);
    chk("R4 entry_pulse", entry_pulse, m_entry);
    chk("R7 exit_pulse", exit_pulse, m_exit);
    chk("R8 frame_ptr", frame_ptr, m_frame);
  endtask

  // one cycle: sample at negedge, then apply next inputs
  task automatic step(input bit v, input logic [31:0] p,
                      input bit e1, input logic [4:0] i1, input logic [31:0] d1,
                      input bit e2, input logic [4:0] i2, input logic [31:0] d2);
    @(negedge clk);
    compare();
    pc_valid = v; pc = p;
    wr1_en = e1; wr1_idx = i1; wr1_data = d1;
    wr2_en = e2; wr2_idx = i2; wr2_data = d2;
  endtask

  task automatic idle(input logic [31:0] p);
    step(1, p, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic setsp(input logic [31:0] p, input logic [31:0] v);
    step(1, p, 1, 29, v, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 scope reset", scope_active, 0);
    chk("R1 entry reset", entry_pulse, 0);
    chk("R1 exit reset", exit_pulse, 0);
    chk("R1 frame reset", frame_ptr, 0);
    rst_n = 1;

    // R2: port1 to SP, port2 to another register
    step(1, 32'h100, 1, 29, 32'h1000, 1, 5, 32'h7777);
    idle(32'h104);
    // R5: match without valid
    step(0, FA, 0, 0, 0, 0, 0, 0);
    idle(32'h108);
    @(negedge clk);
    chk("R5 no entry on invalid pc", scope_active, 0);
    // R4 entry, frame 0x1000 (R2)
    step(1, FA, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    chk("R4 entry pulse", entry_pulse, 1);
    chk("R2 frame from port1 SP", frame_ptr, 32'h1000);
    // R6: inside prologue push and pop back: no exit
    setsp(FA + 4, 32'h0FE0);
    setsp(FA + 8, 32'h1000);
    idle(FA + 8);
    idle(FA + 8);
    @(negedge clk);
    chk("R6 no exit during prologue", scope_active, 1);
    // leave prologue, push frame exactly
    setsp(FA + 12, 32'h0FE0);
    idle(FA + 16);
    idle(FA + 20);
    // R8 nested entry, deeper stack then back to inner frame
    idle(FA);
    setsp(FA + 4, 32'h0FC0);
    idle(32'h200);
    setsp(32'h204, 32'h0FE0);
    idle(32'h208);
    @(negedge clk);
    chk("R8 nested keeps scope", scope_active, 1);
    chk("R8 nested keeps frame", frame_ptr, 32'h1000);
    // R7 pop back to frame
    setsp(32'h20C, 32'h1000);
    idle(32'h210);
    @(negedge clk);
    chk("R7 exit pulse", exit_pulse, 1);
    chk("R7 scope closed", scope_active, 0);
    // R3 both ports on SP
    step(1, 32'h300, 1, 29, 32'h2222, 1, 29, 32'h3330);
    idle(32'h304);
    idle(FA);
    idle(32'h308);
    @(negedge clk);
    chk("R3 port2 wins", frame_ptr, 32'h3330);

    // randomized phase
    for (int n = 0; n < 3000; n++) begin
      int r;
      logic [31:0] p, v;
      r = $urandom_range(0, 7);
      p = (r < 2) ? FA : (r < 4) ? FA + 4 * $urandom_range(1, 4) : 32'h400 + 4 * r;
      v = 32'h0F80 + 32'h10 * $urandom_range(0, 12);
      step($urandom_range(0, 5) != 0, p,
           $urandom_range(0, 3) == 0, ($urandom_range(0, 1) != 0) ? 5'd29 : 5'd3, v,
           $urandom_range(0, 5) == 0, ($urandom_range(0, 1) != 0) ? 5'd29 : 5'd7, v + 32'h20);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule